// File: doc/BRIEF.md
# DDR DRAM Command Decoder and Bank State Tracker

This block is the command front end of a four-bank double-data-rate DRAM model. On every rising clock edge it samples the clock enable, the active-low select and strobe pins, the bank select and the address bus. It turns the pin pattern into one decoded command and keeps, for each bank, an idle/active flag, the row that was last opened and a countdown for a pending auto-precharge. It also tracks the programmed burst length, any burst still in flight and self-refresh.

Commands that break the bank rules are still reported, with an illegal flag set and no state change. Address bit 8 does two jobs. On a read or write it requests auto-precharge. On a precharge it chooses between all banks and the bank named by the bank select. Timing parameters other than read latency and burst length are not enforced. There is no data path.

Every decoded result is registered. A command sampled at a rising edge shows on the `cmd_*` outputs, and in the bank status, right after that same edge. It stays there for exactly one cycle.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With the clock enable high at this edge and at the previous one, and `sel_n` low, the pins {`row_strobe_n`,`col_strobe_n`,`wr_en_n`} decode as follows:
  - 011 is ACTIVATE, code 1.
  - 101 is READ, code 2.
  - 100 is WRITE, code 3.
  - 010 is PRECHARGE, code 4 with `addr[8]` low or code 5 with `addr[8]` high.
  - 001 is REFRESH, code 6.
  - 000 is MODE SET, code 8.
  - 110 is TERMINATE, code 9.
  - 111 is NOP, with no strobe.
  A decoded command raises `cmd_valid` for one cycle after the sampling edge, with `cmd_code` set. `cmd_illegal` is only ever high together with `cmd_valid`.
- R2: With `sel_n` high (deselect) or a NOP, no strobe is produced, the other pins are ignored and no bank state changes.
- R3: ACTIVATE to an idle bank makes it active and stores `addr[10:0]` as its row in `open_rows[b*11 +: 11]`. `cmd_bank` and `cmd_addr` echo the bank and the row.
- R4: ACTIVATE to a bank that is already active raises `cmd_illegal` for one cycle and leaves the bank state and all open rows unchanged.
- R5: READ or WRITE to an idle bank is illegal and changes nothing. A legal READ or WRITE reports the column `addr[7:0]` zero-extended on `cmd_addr`, and reports `addr[8]` on `cmd_autopre`.
- R6: PRECHARGE with `addr[8]` low closes only the selected bank. With `addr[8]` high it closes every bank. Precharging an idle bank is legal.
- R7: A legal READ or WRITE with `addr[8]` high sets the bank's `bank_ap_pend` bit. The bank stays active for N edges after the command and is idle after the Nth. For a WRITE, N is 1 with burst length 2 and 2 with burst length 4. A READ adds the read latency of 3 to that.
- R8: While a bank's auto-precharge is pending, READ, WRITE, ACTIVATE or single-bank PRECHARGE to that bank is illegal. PRECHARGE of all banks is illegal while any auto-precharge is pending.
- R9: MODE SET is illegal unless all banks are idle and no burst is in flight. A burst is in flight for the same N edges as in R7, whether or not auto-precharge is set. With bank select 0, `addr[2:0]` = 001 selects burst length 2 and 010 selects burst length 4 (`burst_len4` high). Any other value is illegal. With any other bank select, a legal MODE SET has no effect on state.
- R10: REFRESH is legal only when all banks are idle.
- R11: The REFRESH pin pattern with the clock enable high at the previous edge and low now is self-refresh entry, code 7. It is legal only when all banks are idle, and a legal entry sets `self_refresh`. Whenever the clock enable was low at the previous edge, the pins are ignored. `self_refresh` clears at the first edge with the clock enable high.
- R12: A synchronous active-high reset leaves:
  - all banks idle and all open rows zero;
  - burst length 2;
  - every output low;
  - the previous clock enable taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable pin |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Bank select |
| addr | input | 11 | Address bus: row, column, bit 8 control, mode field |
| cmd_valid | output | 1 | One-cycle strobe of a decoded command |
| cmd_code | output | 4 | Decoded command code (see R1, R11) |
| cmd_bank | output | 2 | Bank of the decoded command |
| cmd_addr | output | 11 | Row, zero-extended column or mode value |
| cmd_autopre | output | 1 | Auto-precharge requested by READ/WRITE |
| cmd_illegal | output | 1 | Decoded command broke a bank rule |
| bank_active | output | 4 | Per-bank active flag |
| bank_ap_pend | output | 4 | Per-bank auto-precharge pending |
| open_rows | output | 44 | Per-bank open row, bank b at bits b*11 +: 11 |
| burst_len4 | output | 1 | Burst length 4 when high, 2 when low |
| self_refresh | output | 1 | Self-refresh mode entered |

## Verification
The bench targets the auto-precharge window edges, and it checks both burst lengths for writes and for reads with the latency added. A countdown that is off by one would close the bank one cycle early or late, and a bench check placed on the last active edge would catch it.

A burst without auto-precharge is followed by a precharge, so the in-flight window is the only thing that can make a mode set illegal. A tracker that looked only at bank state would accept the mode set early.

Self-refresh entry and exit are driven around clock-enable transitions, because a decoder that ignored the previous clock enable would act on the first command after wake-up. The bench also checks that rejected commands really leave the stored row and the bank flags untouched.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_RD   = 4'd2,
        C_WR   = 4'd3,
        C_PRE  = 4'd4,
        C_PREA = 4'd5,
        C_REF  = 4'd6,
        C_SREF = 4'd7,
        C_MRS  = 4'd8,
        C_TERM = 4'd9
    } cmd_e;

    localparam logic [2:0] MODE_BL2 = 3'b001;
    localparam logic [2:0] MODE_BL4 = 3'b010;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic sel_n_i,
    input  logic row_n_i,
    input  logic col_n_i,
    input  logic we_n_i,
    input  logic ap_bit_i,
    output cmd_e cmd_o
);
    logic run;
    logic enter_low;

    assign run       = cke_prev_i && cke_i;
    assign enter_low = cke_prev_i && !cke_i;

    always_comb begin
        cmd_o = C_NOP;
        if (!sel_n_i) begin
            unique case ({row_n_i, col_n_i, we_n_i})
                3'b011: cmd_o = run ? C_ACT : C_NOP;
                3'b101: cmd_o = run ? C_RD : C_NOP;
                3'b100: cmd_o = run ? C_WR : C_NOP;
                3'b010: cmd_o = run ? (ap_bit_i ? C_PREA : C_PRE) : C_NOP;
                3'b001: cmd_o = run ? C_REF : (enter_low ? C_SREF : C_NOP);
                3'b000: cmd_o = run ? C_MRS : C_NOP;
                3'b110: cmd_o = run ? C_TERM : C_NOP;
                3'b111: cmd_o = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
    parameter int ROW_W = 11,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    input  logic             ap_load_i,
    input  logic [CNT_W-1:0] ap_len_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ap_pend_o
);
    typedef struct packed {
        logic             active;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.cnt != '0) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
            if (slot_q.cnt == CNT_W'(1)) begin
                slot_d.active = 1'b0;
            end
        end
        if (close_i) begin
            slot_d.active = 1'b0;
        end
        if (open_i) begin
            slot_d.active = 1'b1;
            slot_d.row    = row_i;
        end
        if (ap_load_i) begin
            slot_d.cnt = ap_len_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign active_o  = slot_q.active;
    assign row_o     = slot_q.row;
    assign ap_pend_o = (slot_q.cnt != '0);
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int ROW_W   = 11,
    parameter int COL_W   = 8,
    parameter int AP_BIT  = 8,
    parameter int CAS_LAT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clk_en,
    input  logic                   sel_n,
    input  logic                   row_strobe_n,
    input  logic                   col_strobe_n,
    input  logic                   wr_en_n,
    input  logic [$clog2(BANKS)-1:0] bank_sel,
    input  logic [ROW_W-1:0]       addr,
    output logic                   cmd_valid,
    output logic [3:0]             cmd_code,
    output logic [$clog2(BANKS)-1:0] cmd_bank,
    output logic [ROW_W-1:0]       cmd_addr,
    output logic                   cmd_autopre,
    output logic                   cmd_illegal,
    output logic [BANKS-1:0]       bank_active,
    output logic [BANKS-1:0]       bank_ap_pend,
    output logic [BANKS*ROW_W-1:0] open_rows,
    output logic                   burst_len4,
    output logic                   self_refresh
);
    localparam int BA_W    = $clog2(BANKS);
    localparam int BL2_CLK = 1;
    localparam int BL4_CLK = 2;
    localparam int CNT_W   = $clog2(CAS_LAT + BL4_CLK + 1);

    typedef struct packed {
        logic             valid;
        cmd_e             code;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic             ap;
        logic             illegal;
        logic             bl4;
        logic             sref;
        logic             cke_prev;
        logic [CNT_W-1:0] burst_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cmd_e dec_cmd;

    logic [BANKS-1:0] act_req;
    logic [BANKS-1:0] close_req;
    logic [BANKS-1:0] ap_load;
    logic [CNT_W-1:0] burst_len_clk;
    logic [ROW_W-1:0] row_q [BANKS];

    ddr_cmd_decode u_dec (
        .cke_prev_i (ctl_q.cke_prev),
        .cke_i      (clk_en),
        .sel_n_i    (sel_n),
        .row_n_i    (row_strobe_n),
        .col_n_i    (col_strobe_n),
        .we_n_i     (wr_en_n),
        .ap_bit_i   (addr[AP_BIT]),
        .cmd_o      (dec_cmd)
    );

    assign burst_len_clk = CNT_W'(ctl_q.bl4 ? BL4_CLK : BL2_CLK)
                         + ((dec_cmd == C_RD) ? CNT_W'(CAS_LAT) : CNT_W'(0));

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.valid   = 1'b0;
        ctl_d.code    = C_NOP;
        ctl_d.bank    = '0;
        ctl_d.addr    = '0;
        ctl_d.ap      = 1'b0;
        ctl_d.illegal = 1'b0;
        ctl_d.cke_prev = clk_en;
        act_req   = '0;
        close_req = '0;
        ap_load   = '0;

        if (ctl_q.burst_cnt != '0) begin
            ctl_d.burst_cnt = ctl_q.burst_cnt - 1'b1;
        end
        if (clk_en) begin
            ctl_d.sref = 1'b0;
        end
        if (dec_cmd != C_NOP) begin
            ctl_d.valid = 1'b1;
            ctl_d.code  = dec_cmd;
        end

        unique case (dec_cmd)
            C_ACT: begin
                ctl_d.bank = bank_sel;
                ctl_d.addr = addr;
                if (bank_active[bank_sel]) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    act_req[bank_sel] = 1'b1;
                end
            end
            C_RD, C_WR: begin
                ctl_d.bank = bank_sel;
                ctl_d.addr = ROW_W'(addr[COL_W-1:0]);
                ctl_d.ap   = addr[AP_BIT];
                if (!bank_active[bank_sel] || bank_ap_pend[bank_sel]) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    ctl_d.burst_cnt = burst_len_clk;
                    ap_load[bank_sel] = addr[AP_BIT];
                end
            end
            C_PRE: begin
                ctl_d.bank = bank_sel;
                if (bank_ap_pend[bank_sel]) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    close_req[bank_sel] = 1'b1;
                end
            end
            C_PREA: begin
                if (|bank_ap_pend) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    close_req = '1;
                end
            end
            C_REF: begin
                ctl_d.illegal = |bank_active;
            end
            C_SREF: begin
                if (|bank_active) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    ctl_d.sref = 1'b1;
                end
            end
            C_MRS: begin
                ctl_d.bank = bank_sel;
                ctl_d.addr = addr;
                if ((|bank_active) || (ctl_q.burst_cnt != '0)) begin
                    ctl_d.illegal = 1'b1;
                end else if (bank_sel == '0) begin
                    if (addr[2:0] == MODE_BL2) begin
                        ctl_d.bl4 = 1'b0;
                    end else if (addr[2:0] == MODE_BL4) begin
                        ctl_d.bl4 = 1'b1;
                    end else begin
                        ctl_d.illegal = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q          <= '0;
            ctl_q.cke_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        ddr_bank_slot #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .open_i    (act_req[b]),
            .row_i     (addr),
            .close_i   (close_req[b]),
            .ap_load_i (ap_load[b]),
            .ap_len_i  (burst_len_clk),
            .active_o  (bank_active[b]),
            .row_o     (row_q[b]),
            .ap_pend_o (bank_ap_pend[b])
        );
        assign open_rows[b*ROW_W +: ROW_W] = row_q[b];
    end

    assign cmd_valid    = ctl_q.valid;
    assign cmd_code     = ctl_q.code;
    assign cmd_bank     = ctl_q.bank;
    assign cmd_addr     = ctl_q.addr;
    assign cmd_autopre  = ctl_q.ap;
    assign cmd_illegal  = ctl_q.illegal;
    assign burst_len4   = ctl_q.bl4;
    assign self_refresh = ctl_q.sref;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk
    import ddr_cmd_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 11
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [3:0]               cmd_code,
    input logic [$clog2(BANKS)-1:0] cmd_bank,
    input logic                     cmd_illegal,
    input logic [BANKS-1:0]         bank_active,
    input logic [BANKS-1:0]         bank_ap_pend,
    input logic [BANKS*ROW_W-1:0]   open_rows,
    input logic                     self_refresh
);
    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> (bank_active == '0 && open_rows == '0 && !cmd_valid));

    assert_illegal_strobed_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_illegal |-> cmd_valid);

    assert_reject_keeps_rows_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_illegal |-> $stable(open_rows));

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'(C_ACT) && !cmd_illegal) |-> bank_active[cmd_bank]);

    assert_pend_in_active_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_ap_pend & ~bank_active) == '0);

    assert_pend_end_closes_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(bank_ap_pend) & ~bank_ap_pend & bank_active) == '0);

    assert_mode_all_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'(C_MRS) && !cmd_illegal) |-> bank_active == '0);

    assert_sref_all_idle_R11: assert property (@(posedge clk) disable iff (rst)
        self_refresh |-> bank_active == '0);
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
    .BANKS (BANKS),
    .ROW_W (ROW_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .cmd_bank     (cmd_bank),
    .cmd_illegal  (cmd_illegal),
    .bank_active  (bank_active),
    .bank_ap_pend (bank_ap_pend),
    .open_rows    (open_rows),
    .self_refresh (self_refresh)
);

// File: tb/ddr_cmd_tracker_test.sv
module ddr_cmd_tracker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        sel_n = 1'b1;
    logic        row_strobe_n = 1'b1;
    logic        col_strobe_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic [10:0] addr = '0;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [10:0] cmd_addr;
    logic        cmd_autopre;
    logic        cmd_illegal;
    logic [3:0]  bank_active;
    logic [3:0]  bank_ap_pend;
    logic [43:0] open_rows;
    logic        burst_len4;
    logic        self_refresh;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ddr_cmd_tracker uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel_n(sel_n),
        .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
        .bank_sel(bank_sel), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre),
        .cmd_illegal(cmd_illegal), .bank_active(bank_active), .bank_ap_pend(bank_ap_pend),
        .open_rows(open_rows), .burst_len4(burst_len4), .self_refresh(self_refresh)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(bit ce, bit s, bit r, bit c, bit w, logic [1:0] b, logic [10:0] a);
        clk_en = ce; sel_n = s; row_strobe_n = r; col_strobe_n = c; wr_en_n = w;
        bank_sel = b; addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();                            drive(1, 0, 1, 1, 1, 2'd0, 11'd0); endtask
    task automatic act(logic [1:0] b, logic [10:0] a); drive(1, 0, 0, 1, 1, b, a); endtask
    task automatic rd(logic [1:0] b, logic [10:0] a);  drive(1, 0, 1, 0, 1, b, a); endtask
    task automatic wr(logic [1:0] b, logic [10:0] a);  drive(1, 0, 1, 0, 0, b, a); endtask
    task automatic pre(logic [1:0] b, bit all);        drive(1, 0, 0, 1, 0, b, {2'b00, all, 8'h00}); endtask
    task automatic refr();                           drive(1, 0, 0, 0, 1, 2'd0, 11'd0); endtask
    task automatic mrs(logic [1:0] b, logic [10:0] a); drive(1, 0, 0, 0, 0, b, a); endtask

    task automatic do_reset();
        rst = 1'b1;
        nop();
        rst = 1'b0;
    endtask

    function automatic logic [10:0] row_of(int b);
        return open_rows[b*11 +: 11];
    endfunction

    task automatic t_reset();
        mrs(2'd0, 11'h002);
        act(2'd0, 11'h111);
        do_reset();
        chk("R12 active", bank_active, 0);
        chk("R12 rows", open_rows, 0);
        chk("R12 bl", burst_len4, 0);
        chk("R12 valid", cmd_valid, 0);
        chk("R12 sref", self_refresh, 0);
    endtask

    task automatic t_deselect();
        do_reset();
        drive(1, 1, 0, 1, 1, 2'd1, 11'h0AA);
        chk("R2 deselect valid", cmd_valid, 0);
        chk("R2 deselect active", bank_active, 0);
        nop();
        chk("R2 nop valid", cmd_valid, 0);
        drive(1, 0, 1, 1, 0, 2'd0, 11'd0);
        chk("R1 term code", {cmd_valid, cmd_code, cmd_illegal}, {1'b1, 4'd9, 1'b0});
    endtask

    task automatic t_activate();
        do_reset();
        act(2'd1, 11'h5A3);
        chk("R1 act code", {cmd_valid, cmd_code, cmd_illegal}, {1'b1, 4'd1, 1'b0});
        chk("R3 act bank/addr", {cmd_bank, cmd_addr}, {2'd1, 11'h5A3});
        chk("R3 act state", bank_active, 4'b0010);
        chk("R3 row", row_of(1), 11'h5A3);
        act(2'd1, 11'h07F);
        chk("R4 re-act illegal", cmd_illegal, 1);
        chk("R4 row kept", row_of(1), 11'h5A3);
        chk("R4 state kept", bank_active, 4'b0010);
        nop();
        chk("R4 pulse", cmd_illegal, 0);
    endtask

    task automatic t_rw_idle();
        do_reset();
        act(2'd1, 11'h001);
        rd(2'd2, 11'h012);
        chk("R5 rd idle illegal", {cmd_code, cmd_illegal}, {4'd2, 1'b1});
        chk("R5 rd idle state", bank_active, 4'b0010);
        wr(2'd0, 11'h013);
        chk("R5 wr idle illegal", {cmd_code, cmd_illegal}, {4'd3, 1'b1});
        rd(2'd1, 11'h63C);
        chk("R5 rd legal", {cmd_code, cmd_illegal, cmd_autopre}, {4'd2, 1'b0, 1'b0});
        chk("R5 column", cmd_addr, 11'h03C);
        chk("R5 no pend", bank_ap_pend, 0);
    endtask

    task automatic t_precharge();
        do_reset();
        act(2'd0, 11'h100);
        act(2'd1, 11'h101);
        act(2'd2, 11'h102);
        pre(2'd1, 1'b0);
        chk("R6 single code", {cmd_code, cmd_illegal}, {4'd4, 1'b0});
        chk("R6 single", bank_active, 4'b0101);
        pre(2'd3, 1'b0);
        chk("R6 idle pre legal", {cmd_illegal, bank_active}, {1'b0, 4'b0101});
        pre(2'd0, 1'b1);
        chk("R6 all code", {cmd_code, cmd_illegal}, {4'd5, 1'b0});
        chk("R6 all", bank_active, 0);
    endtask

    task automatic t_burst_window();
        do_reset();
        act(2'd0, 11'h010);
        rd(2'd0, 11'h004);
        pre(2'd0, 1'b0);
        chk("R9 closed", bank_active, 0);
        mrs(2'd0, 11'h002);
        chk("R9 busy mode illegal", {cmd_code, cmd_illegal}, {4'd8, 1'b1});
        nop();
        mrs(2'd0, 11'h002);
        chk("R9 last busy edge", {cmd_illegal, burst_len4}, {1'b1, 1'b0});
        mrs(2'd0, 11'h002);
        chk("R9 bl4 set", {cmd_illegal, burst_len4}, {1'b0, 1'b1});
        mrs(2'd0, 11'h003);
        chk("R9 bad code", {cmd_illegal, burst_len4}, {1'b1, 1'b1});
        mrs(2'd2, 11'h001);
        chk("R9 other bank", {cmd_illegal, burst_len4}, {1'b0, 1'b1});
        act(2'd3, 11'h000);
        mrs(2'd0, 11'h001);
        chk("R9 active illegal", {cmd_illegal, burst_len4}, {1'b1, 1'b1});
    endtask

    task automatic t_ap_write();
        do_reset();
        mrs(2'd0, 11'h002);
        act(2'd3, 11'h2F0);
        wr(2'd3, 11'h105);
        chk("R7 wr4 start", {cmd_autopre, bank_ap_pend, bank_active}, {1'b1, 4'b1000, 4'b1000});
        rd(2'd3, 11'h005);
        chk("R8 rd pend illegal", cmd_illegal, 1);
        chk("R7 wr4 edge1", bank_active, 4'b1000);
        nop();
        chk("R7 wr4 idle", {bank_active, bank_ap_pend}, 8'h00);
        mrs(2'd0, 11'h001);
        act(2'd0, 11'h033);
        wr(2'd0, 11'h100);
        chk("R7 wr2 start", bank_ap_pend, 4'b0001);
        nop();
        chk("R7 wr2 idle", {bank_active, bank_ap_pend}, 8'h00);
    endtask

    task automatic t_ap_read();
        do_reset();
        mrs(2'd0, 11'h002);
        act(2'd2, 11'h044);
        act(2'd1, 11'h055);
        rd(2'd2, 11'h1AA);
        chk("R7 rd start", bank_ap_pend, 4'b0100);
        pre(2'd2, 1'b0);
        chk("R8 pre pend illegal", {cmd_illegal, bank_active}, {1'b1, 4'b0110});
        pre(2'd1, 1'b1);
        chk("R8 pre all illegal", {cmd_illegal, bank_active}, {1'b1, 4'b0110});
        act(2'd2, 11'h000);
        chk("R8 act pend illegal", cmd_illegal, 1);
        nop();
        chk("R7 rd edge4 active", bank_active[2], 1);
        nop();
        chk("R7 rd edge5 idle", {bank_active, bank_ap_pend}, {4'b0010, 4'b0000});
        chk("R7 row kept", row_of(2), 11'h044);
    endtask

    task automatic t_refresh();
        do_reset();
        act(2'd0, 11'h001);
        refr();
        chk("R10 ref busy", {cmd_code, cmd_illegal}, {4'd6, 1'b1});
        pre(2'd0, 1'b1);
        refr();
        chk("R10 ref idle", {cmd_code, cmd_illegal}, {4'd6, 1'b0});
    endtask

    task automatic t_selfref();
        do_reset();
        drive(0, 0, 0, 0, 1, 2'd0, 11'd0);
        chk("R11 entry", {cmd_code, cmd_illegal, self_refresh}, {4'd7, 1'b0, 1'b1});
        drive(0, 0, 0, 1, 1, 2'd0, 11'h005);
        chk("R11 ignored low", {cmd_valid, bank_active, self_refresh}, {1'b0, 4'b0000, 1'b1});
        drive(1, 0, 0, 1, 1, 2'd0, 11'h005);
        chk("R11 wake ignored", {cmd_valid, bank_active, self_refresh}, {1'b0, 4'b0000, 1'b0});
        act(2'd0, 11'h005);
        chk("R11 act after wake", {cmd_illegal, bank_active}, {1'b0, 4'b0001});
        drive(0, 0, 0, 0, 1, 2'd0, 11'd0);
        chk("R11 entry busy", {cmd_code, cmd_illegal, self_refresh}, {4'd7, 1'b1, 1'b0});
        nop();
        chk("R11 after powerdown", cmd_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R12 initial valid", cmd_valid, 0);
        chk("R12 initial active", bank_active, 0);
        t_reset();
        t_deselect();
        t_activate();
        t_rw_idle();
        t_precharge();
        t_burst_window();
        t_ap_write();
        t_ap_read();
        t_refresh();
        t_selfref();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule